// File: doc/BRIEF.md
# Bridge Header Register File with Per-Bit Access Attributes

This block holds the sixteen 32-bit dwords of a type-1 (bridge) configuration header for a root port that is emulated in logic. A simple register bus reaches it: a dword index, a byte offset, an access size of 1, 2 or 4 bytes and write data. Every bit of every dword has one of four attributes: read-only, read-write, write-one-to-clear, or reserved. The attribute decides what a read returns and which bits a write can change.

Three mode straps reshape the attributes. The first selects PCI Express operation, which turns a set of conventional-PCI-only fields into reserved bits. The second disables I/O forwarding, which freezes the I/O window and the I/O enable bit. The third disables prefetchable forwarding, which freezes the prefetchable window. Hardware error events set the write-one-to-clear status bits. Software then clears them by writing ones.

Top module: `cfg_hdr_regs`

## Requirements
- R1: A reserved bit always reads 0, whatever value is stored for it. A read-only bit reads its reset value and no write changes it.
- R2: The read path has three cases. A 4-byte read returns the whole dword and ignores the byte offset. A 2-byte read returns (dword >> 8·offset) & 0xFFFF. A 1-byte read returns (dword >> 8·offset) & 0xFF.
- R3: An access size other than 1, 2 or 4 answers with rsp_err=1 and read data 0, and a write of that size changes nothing.
- R4: A write builds a lane mask: all ones for 4 bytes (offset ignored), 0xFFFF<<8·offset for 2 bytes, and 0xFF<<8·offset for 1 byte. Only bits that are read-write and inside the mask take the new data.
- R5: A write-one-to-clear bit inside the lane mask clears when its data bit is 1. It stays as it is when the data bit is 0 or when it lies outside the mask.
- R6: Dword 6 has read-write bits 23:0 (bus numbers) and read-only bits 31:24. Dword 7 has read-write bits 15:12 and 7:4 and read-only bits 11:8 and 3:0. Dwords 8 and 9 have read-write bits 31:20 and 15:4 and read-only bits 19:16 and 3:0. Dwords 10, 11 and 12 are fully read-write.
- R7: With strap_no_pref=1, dword 9 is entirely read-only.
- R8: With strap_no_io=1, three things change: command bit 0 (dword 1) is read-only, bits 15:0 of dword 7 are read-only, and dword 12 is read-only.
- R9: With strap_pcie=1, the following bits become reserved: the command bits 3,4,5,7,9; the status bits 21,23,25,26 of dwords 1 and 7; dword 3 bits 15:8; dword 6 bits 31:24; and dword 15 bits 21,24,25,26,27,23. The dword 1 attribute is then rw=0x147, ro=0x00100000 and w1c=0xF9000000.
- R10: The reset values are: dword 0 = {DEV_ID,VEN_ID}; dword 1 bit 20 = 1 when CAP_PTR is nonzero; dword 2 = {0x060400,REV_ID}; dword 3 = 0x00010010; dword 9 = 0x00010001 when PREF64; dword 13 = CAP_PTR; dword 15 bits 15:8 = INT_PIN. Every other bit resets to 0.
- R11: The event inputs set write-one-to-clear bits. Bits 0..5 of ev_pri_err set dword 1 bits 24,27,28,29,30,31. Bits 0..5 of ev_sec_err set the same bit positions in dword 7. ev_discard sets dword 15 bit 26. An event is ignored where its bit is not write-one-to-clear in the current mode. When an event and a software clear hit the same cycle, the event wins.
- R12: Every request produces rsp_valid one cycle later. A read issued in the cycle after a write returns the merged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_pcie | input | 1 | PCI Express mode |
| strap_no_io | input | 1 | I/O forwarding disabled |
| strap_no_pref | input | 1 | Prefetchable forwarding disabled |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Dword index |
| req_boff | input | 2 | Byte offset inside the dword |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| ev_pri_err | input | 6 | Primary status error events |
| ev_sec_err | input | 6 | Secondary status error events |
| ev_discard | input | 1 | Discard timer event |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Bad access size |
| rsp_rdata | output | 32 | Read data, right-aligned |

## Verification
The assertions check on every cycle the rules that hold for any register. They cover the one-cycle response timing, the error-and-zero answer to a bad size, the zero upper lanes of sub-word reads, and the fixed identity and header-type fields. The per-bit attribute of each dword in each of the eight strap combinations can only be shown by the bench scenarios. The same holds for the lane-masked merge, the write-one-to-clear semantics and the event-over-clear priority, because each of these depends on stored history.

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs #(
  parameter int          AW      = 4,
  parameter logic [15:0] VEN_ID  = 16'hA5C3,
  parameter logic [15:0] DEV_ID  = 16'h0F17,
  parameter logic [7:0]  REV_ID  = 8'h01,
  parameter logic [7:0]  CAP_PTR = 8'h40,
  parameter logic [7:0]  INT_PIN = 8'h01,
  parameter bit          PREF64  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_pcie,
  input  logic          strap_no_io,
  input  logic          strap_no_pref,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_boff,
  input  logic [2:0]    req_size,
  input  logic [31:0]   req_wdata,
  input  logic [5:0]    ev_pri_err,
  input  logic [5:0]    ev_sec_err,
  input  logic          ev_discard,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [31:0]   rsp_rdata
);
  localparam int NREG = 1 << AW;

  function automatic logic [95:0] attr(input int i, input logic pe, ni, np);
    logic [31:0] ro, rw, wc;
    ro = '0; rw = '0; wc = '0;
    case (i)
      0, 2, 4, 5, 14: ro = '1;
      1: begin
        rw = 32'h0000_0147;
        ro = pe ? 32'h0010_0000 : 32'h06B0_02B8;
        wc = 32'hF900_0000;
        if (ni) begin ro[0] = 1'b1; rw[0] = 1'b0; end
      end
      3: ro = pe ? 32'hFFFF_00FF : '1;
      6: begin rw = 32'h00FF_FFFF; ro = pe ? 32'h0 : 32'hFF00_0000; end
      7: begin
        rw = 32'h0000_F0F0;
        ro = pe ? 32'h0000_0F0F : 32'h06A0_0F0F;
        wc = 32'hF900_0000;
        if (ni) begin rw = '0; ro[15:0] = 16'hFFFF; end
      end
      8: begin rw = 32'hFFF0_FFF0; ro = 32'h000F_000F; end
      9: if (np) ro = '1;
         else begin rw = 32'hFFF0_FFF0; ro = 32'h000F_000F; end
      10, 11: rw = '1;
      12: if (ni) ro = '1; else rw = '1;
      13: ro = 32'h0000_00FF;
      15: begin
        rw = pe ? 32'h004F_00FF : 32'h0B6F_00FF;
        ro = pe ? 32'h0000_FF00 : 32'h0080_FF00;
        wc = pe ? 32'h0 : 32'h0400_0000;
      end
      default: ;
    endcase
    return {ro, rw, wc};
  endfunction

  function automatic logic [31:0] rst_val(input int i);
    case (i)
      0:  return {DEV_ID, VEN_ID};
      1:  return {11'h0, (CAP_PTR != 8'h0), 20'h0};
      2:  return {24'h060400, REV_ID};
      3:  return 32'h0001_0010;
      9:  return PREF64 ? 32'h0001_0001 : 32'h0;
      13: return {24'h0, CAP_PTR};
      15: return {16'h0, INT_PIN, 8'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] err_map(input logic [5:0] e);
    return {e[5:1], 2'b00, e[0], 24'h0};
  endfunction

  logic [31:0] st   [NREG];
  logic [31:0] ro_m [NREG];
  logic [31:0] rw_m [NREG];
  logic [31:0] wc_m [NREG];
  logic [31:0] ev_m [NREG];

  logic        size_ok;
  logic [4:0]  sh;
  logic [31:0] lane, wsh, rsel, rshift;

  assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign sh      = (req_size == 3'd4) ? 5'd0 : {req_boff, 3'b000};
  assign wsh     = req_wdata << sh;
  assign lane    = (req_size == 3'd4) ? 32'hFFFF_FFFF :
                   (req_size == 3'd2) ? (32'h0000_FFFF << sh) :
                   (req_size == 3'd1) ? (32'h0000_00FF << sh) : 32'h0;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic        hit;
    logic [31:0] merged;
    assign {ro_m[g], rw_m[g], wc_m[g]} = attr(g, strap_pcie, strap_no_io, strap_no_pref);
    assign ev_m[g] = (g == 1)  ? err_map(ev_pri_err) :
                     (g == 7)  ? err_map(ev_sec_err) :
                     (g == 15) ? {5'h0, ev_discard, 26'h0} : 32'h0;
    assign hit    = req_valid && req_write && size_ok && (req_addr == AW'(g));
    assign merged = ((st[g] & ~(rw_m[g] & lane)) | (wsh & rw_m[g] & lane))
                    & ~(wsh & wc_m[g] & lane);
    always_ff @(posedge clk) begin
      if (!rst_n) st[g] <= rst_val(g);
      else        st[g] <= (hit ? merged : st[g]) | (ev_m[g] & wc_m[g]);
    end
  end

  assign rsel   = st[req_addr] & (ro_m[req_addr] | rw_m[req_addr] | wc_m[req_addr]);
  assign rshift = rsel >> sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !size_ok;
      if (!req_valid || req_write || !size_ok) rsp_rdata <= '0;
      else if (req_size == 3'd1)               rsp_rdata <= rshift & 32'h0000_00FF;
      else if (req_size == 3'd2)               rsp_rdata <= rshift & 32'h0000_FFFF;
      else                                     rsp_rdata <= rsel;
    end
  end
endmodule

// File: rtl/cfg_hdr_regs_chk.sv
module cfg_hdr_regs_chk #(
  parameter int          AW     = 4,
  parameter logic [15:0] VEN_ID = 16'hA5C3,
  parameter logic [15:0] DEV_ID = 16'h0F17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [2:0]    req_size,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [31:0]   rsp_rdata
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_rsp_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rsp_valid == $past(req_valid)));

  p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rsp_valid && $past(req_size != 3'd1 && req_size != 3'd2 && req_size != 3'd4))
    |-> (rsp_err && rsp_rdata == 32'h0));

  p_byte_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rsp_valid && $past(req_size == 3'd1)) |-> (rsp_rdata[31:8] == 24'h0));

  p_half_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rsp_valid && $past(req_size == 3'd2)) |-> (rsp_rdata[31:16] == 16'h0));

  p_ident_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rsp_valid && $past(!req_write && req_addr == AW'(0) && req_size == 3'd4))
    |-> (rsp_rdata == {DEV_ID, VEN_ID}));

  p_hdr_type_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rsp_valid && $past(!req_write && req_addr == AW'(3) && req_size == 3'd4))
    |-> (rsp_rdata[23:16] == 8'h01 && rsp_rdata[7:0] == 8'h10));
endmodule

bind cfg_hdr_regs cfg_hdr_regs_chk #(.AW(AW), .VEN_ID(VEN_ID), .DEV_ID(DEV_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/sim_cfg_hdr_regs.sv
module sim_cfg_hdr_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pe = 0, ni = 0, np = 0;
  logic req_valid = 0, req_write = 0;
  logic [3:0] req_addr = 0;
  logic [1:0] req_boff = 0;
  logic [2:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic [5:0] ev_pri = 0, ev_sec = 0;
  logic ev_dis = 0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int vecs = 0, fails = 0;
  logic [31:0] mdl [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_hdr_regs u0 (
    .clk(clk), .rst_n(rst_n), .strap_pcie(pe), .strap_no_io(ni), .strap_no_pref(np),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_boff(req_boff),
    .req_size(req_size), .req_wdata(req_wdata), .ev_pri_err(ev_pri), .ev_sec_err(ev_sec),
    .ev_discard(ev_dis), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  // Attribute table written from R6..R9: {ro, rw, w1c}
  function automatic logic [95:0] ex_attr(input int i);
    logic [31:0] ro = 0, rw = 0, wc = 0;
    if (i == 0 || i == 2 || i == 4 || i == 5 || i == 14) ro = '1;
    if (i == 1) begin
      rw = ni ? 32'h146 : 32'h147;
      ro = (pe ? 32'h0010_0000 : 32'h06B0_02B8) | (ni ? 32'h1 : 32'h0);
      wc = 32'hF900_0000;
    end
    if (i == 3) ro = pe ? 32'hFFFF_00FF : 32'hFFFF_FFFF;
    if (i == 6) begin rw = 32'h00FF_FFFF; ro = pe ? 0 : 32'hFF00_0000; end
    if (i == 7) begin
      rw = ni ? 0 : 32'h0000_F0F0;
      ro = (pe ? 32'h0 : 32'h06A0_0000) | (ni ? 32'hFFFF : 32'h0F0F);
      wc = 32'hF900_0000;
    end
    if (i == 8 || (i == 9 && !np)) begin rw = 32'hFFF0_FFF0; ro = 32'h000F_000F; end
    if (i == 9 && np) ro = '1;
    if (i == 10 || i == 11) rw = '1;
    if (i == 12) begin if (ni) ro = '1; else rw = '1; end
    if (i == 13) ro = 32'hFF;
    if (i == 15) begin
      rw = pe ? 32'h004F_00FF : 32'h0B6F_00FF;
      ro = pe ? 32'h0000_FF00 : 32'h0080_FF00;
      wc = pe ? 0 : 32'h0400_0000;
    end
    return {ro, rw, wc};
  endfunction

  function automatic logic [31:0] emap(input logic [5:0] e);
    logic [31:0] r = 0;
    r[24] = e[0]; r[27] = e[1]; r[28] = e[2]; r[29] = e[3]; r[30] = e[4]; r[31] = e[5];
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) mdl[i] = 0;
    mdl[0] = 32'h0F17_A5C3; mdl[1] = 32'h0010_0000; mdl[2] = 32'h0604_0001;
    mdl[3] = 32'h0001_0010; mdl[9] = 32'h0001_0001; mdl[13] = 32'h40; mdl[15] = 32'h0100;
  endtask

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input int a, input int off, input int sz,
                      input logic [31:0] wd, input logic [5:0] ep, input logic [5:0] es,
                      input logic ed, input string rq);
    logic [95:0] at;
    logic [31:0] lane, wsh, vis, exp;
    int sh;
    logic ok;
    at = ex_attr(a);
    ok = (sz == 1 || sz == 2 || sz == 4);
    sh = (sz == 4) ? 0 : off * 8;
    lane = (sz == 4) ? 32'hFFFF_FFFF : (sz == 2) ? (32'hFFFF << sh) : (sz == 1) ? (32'hFF << sh) : 0;
    wsh = wd << sh;
    vis = mdl[a] & (at[95:64] | at[63:32] | at[31:0]);
    exp = !ok ? 0 : (sz == 4) ? vis : (sz == 2) ? ((vis >> sh) & 32'hFFFF) : ((vis >> sh) & 32'hFF);
    if (wr) exp = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 4'(a); req_boff = 2'(off);
    req_size = 3'(sz); req_wdata = wd; ev_pri = ep; ev_sec = es; ev_dis = ed;
    @(negedge clk);
    req_valid = 0; ev_pri = 0; ev_sec = 0; ev_dis = 0;
    if (wr && ok)
      mdl[a] = ((mdl[a] & ~(at[63:32] & lane)) | (wsh & at[63:32] & lane)) & ~(wsh & at[31:0] & lane);
    for (int i = 0; i < 16; i++) begin
      logic [95:0] ai;
      ai = ex_attr(i);
      if (i == 1)  mdl[i] |= emap(ep) & ai[31:0];
      if (i == 7)  mdl[i] |= emap(es) & ai[31:0];
      if (i == 15) mdl[i] |= {5'h0, ed, 26'h0} & ai[31:0];
    end
    check({rq, " R12 valid"}, {31'h0, rsp_valid}, 32'h1);
    check({rq, " R3 err"}, {31'h0, rsp_err}, {31'h0, !ok});
    check({rq, " data"}, rsp_rdata, exp);
  endtask

  task automatic rd(input int a, input int off, input int sz, input string rq);
    xfer(0, a, off, sz, 0, 0, 0, 0, rq);
  endtask

  task automatic wr(input int a, input int off, input int sz, input logic [31:0] d, input string rq);
    xfer(1, a, off, sz, d, 0, 0, 0, rq);
  endtask

  task automatic rd_all(input int a, input string rq);
    rd(a, 0, 4, {rq, " R1 dword"});
    rd(a, 2, 4, {rq, " R2 dword offset ignored"});
    for (int o = 0; o < 4; o += 2) rd(a, o, 2, {rq, " R2 half"});
    for (int o = 0; o < 4; o++) rd(a, o, 1, {rq, " R2 byte"});
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
          fails++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
          $finish;
        end
      end
    join_none

    for (int m = 0; m < 8; m++) begin
      pe = m[0]; ni = m[1]; np = m[2];
      rst_n = 0;
      repeat (3) @(negedge clk);
      check("R12 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
      rst_n = 1;
      model_reset();
      for (int a = 0; a < 16; a++) rd(a, 0, 4, "R10 reset value");
      for (int a = 0; a < 16; a++) begin
        wr(a, 0, 4, 32'hFFFF_FFFF, "R4 R6 R7 R8 R9 full write ones");
        rd_all(a, "R4 R6 R7 R8 R9 after ones");
        wr(a, 0, 4, 32'h0, "R4 full write zeros");
        rd_all(a, "R4 R5 after zeros");
        for (int o = 0; o < 4; o++) begin
          wr(a, o, 1, 32'(8'hA5 ^ 8'(a * 17 + o)), "R4 byte write");
          rd(a, 0, 4, "R4 byte lane merge");
        end
        wr(a, 2, 2, 32'h0000_5AC3, "R4 half write");
        rd(a, 0, 4, "R4 half lane merge");
        wr(a, 0, 3, 32'hFFFF_FFFF, "R3 bad size write");
        rd(a, 0, 4, "R3 bad size write ignored");
        rd(a, 1, 3, "R3 bad size read");
        rd(a, 0, 0, "R3 zero size read");
      end
      xfer(0, 0, 0, 4, 0, 6'h3F, 6'h3F, 1, "R11 events with read");
      rd(1, 0, 4, "R11 primary status set");
      rd(7, 0, 4, "R11 secondary status set");
      rd(15, 0, 4, "R11 discard status set");
      wr(1, 3, 1, 32'h0000_0000, "R5 write zero to w1c");
      rd(1, 0, 4, "R5 zero leaves w1c");
      wr(7, 0, 2, 32'h0000_FFFF, "R5 w1c outside lane");
      rd(7, 0, 4, "R5 outside lane untouched");
      wr(1, 3, 1, 32'h0000_00A1, "R5 partial clear");
      rd(1, 0, 4, "R5 partial clear result");
      xfer(1, 1, 0, 4, 32'hFFFF_FFFF, 6'h01, 6'h00, 0, "R11 set vs clear same cycle");
      rd(1, 0, 4, "R11 set wins");
      xfer(1, 7, 0, 4, 32'hFFFF_FFFF, 6'h00, 6'h20, 0, "R11 secondary set vs clear");
      rd(7, 0, 4, "R11 secondary set wins");
      xfer(1, 15, 0, 4, 32'hFFFF_FFFF, 0, 0, 1, "R11 discard set vs clear");
      rd(15, 0, 4, "R11 discard set wins or ignored");
      wr(10, 0, 4, 32'h1357_9BDF, "R12 write");
      rd(10, 0, 4, "R12 back-to-back read");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule